// File: doc/BRIEF.md
# ADC Result Polling Read Master

This block is an AXI4-Lite master that reads the conversion-result register of a memory-mapped on-chip ADC over and over. It does nothing until a configuration-done level goes high. Software drives that level from a separate control register once it has finished setting up the converter.

While the level is high, the block issues single-beat reads back to back to one fixed address, which is set by a parameter. After each read completes, it starts the next one.

When a read returns an OKAY response, the block takes a 12-bit sample from the read data and presents it on a parallel bus, together with a one-cycle valid strobe. When a read returns an error response, the block keeps the previous sample and increments a saturating error count. The write channels are present but never used.

Top module: `adc_poll_master`

## Requirements
- R1: While the block is idle and `cfg_done` is low, `m_arvalid` stays low; no read address is ever offered in that state.
- R2: Once `m_arvalid` is high, it stays high and `m_araddr` stays unchanged until a cycle in which `m_arready` is high.
- R3: Every read address equals the parameter `RESULT_ADDR`, and `m_arprot` is 3'b000.
- R4: After the address handshake, `m_rready` is high from the next cycle until the cycle in which `m_rvalid` is high. `m_rready` and `m_arvalid` are never high together.
- R5: When a read completes while `cfg_done` is high, `m_arvalid` rises in the very next cycle, so reads follow one another without idle cycles.
- R6: A read with `m_rresp` = 2'b00 (OKAY) loads `sample` with `m_rdata[15:4]`. `sample_vld` is high for exactly the one cycle after the data handshake.
- R7: A read with any non-zero `m_rresp` leaves `sample` unchanged, gives no `sample_vld` pulse, and adds one to `err_cnt` in the cycle after the handshake.
- R8: `err_cnt` saturates at all ones; further errors leave it there.
- R9: If `cfg_done` falls during a read, that read still runs to completion and its result is used. If `cfg_done` is low in the cycle the read completes, no further address is issued and `m_rready` stays low until `cfg_done` rises again.
- R10: The write channels stay inactive: `m_awvalid` and `m_wvalid` are low, `m_bready` is high, and the write address, data and strobes are zero.
- R11: After reset, `m_arvalid`, `m_rready`, `sample`, `sample_vld` and `err_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_done | input | 1 | Converter configured; enables polling |
| m_araddr | output | ADDR_W | Read address |
| m_arprot | output | 3 | Read protection, always zero |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_awaddr | output | ADDR_W | Write address, tied to zero |
| m_awprot | output | 3 | Write protection, tied to zero |
| m_awvalid | output | 1 | Write address valid, held low |
| m_wdata | output | DATA_W | Write data, tied to zero |
| m_wstrb | output | DATA_W/8 | Write strobes, tied to zero |
| m_wvalid | output | 1 | Write data valid, held low |
| m_bready | output | 1 | Write response ready, held high |
| sample | output | SAMPLE_W | Latest good conversion result |
| sample_vld | output | 1 | One-cycle strobe on a new sample |
| err_cnt | output | ERR_W | Saturating count of error responses |

## Verification
The delicate coincidence is a read completing in the same cycle that `cfg_done` falls. The block then has to choose between issuing the next address and going idle, while still capturing the data it has just accepted. The bench provokes this case by removing `cfg_done` in the same cycle it presents `m_rvalid`. It also removes `cfg_done` earlier, while the address is still waiting for `m_arready`. In both cases it expects the sample or the error count to update from that last read, and `m_arvalid` and `m_rready` to stay low afterwards. A second coincidence is an error response arriving while the counter is already full: the count must stay at its maximum, and the held sample must not move.

// File: rtl/adc_poll_pkg.sv
package adc_poll_pkg;

  typedef enum logic [1:0] {
    POLL_IDLE = 2'd0,
    POLL_ADDR = 2'd1,
    POLL_DATA = 2'd2
  } poll_state_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  function automatic logic resp_is_ok(input logic [1:0] resp);
    return resp == RESP_OKAY;
  endfunction

  function automatic poll_state_e next_after_read(input logic enable);
    return enable ? POLL_ADDR : POLL_IDLE;
  endfunction

endpackage

// File: rtl/adc_poll_fsm.sv
module adc_poll_fsm
  import adc_poll_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RESULT_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_done,
  input  logic              arready,
  input  logic              rvalid,
  output logic              arvalid,
  output logic [ADDR_W-1:0] araddr,
  output logic              rready,
  output logic              rd_done
);

  poll_state_e state_q, state_d;
  logic        ar_fire;

  assign arvalid = (state_q == POLL_ADDR);
  assign rready  = (state_q == POLL_DATA);
  assign araddr  = RESULT_ADDR;
  assign ar_fire = arvalid && arready;
  assign rd_done = rready && rvalid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      POLL_IDLE: if (cfg_done) state_d = POLL_ADDR;
      POLL_ADDR: if (ar_fire)  state_d = POLL_DATA;
      POLL_DATA: if (rd_done)  state_d = next_after_read(cfg_done);
      default:                 state_d = POLL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= POLL_IDLE;
    else        state_q <= state_d;
  end

  // R1
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!arvalid && !cfg_done) |=> !arvalid);

  // R2
  ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid && !arready) |=> (arvalid && $stable(araddr)));

  // R4
  r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rready && !rvalid) |=> rready);

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(arvalid && rready));

  // R5
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && cfg_done) |=> arvalid);

  // R9
  drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !cfg_done) |=> (!arvalid && !rready));

endmodule

// File: rtl/adc_sample_capture.sv
module adc_sample_capture
  import adc_poll_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SAMPLE_W   = 12,
  parameter int unsigned SAMPLE_LSB = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_done,
  input  logic [DATA_W-1:0]   rdata,
  input  logic [1:0]          rresp,
  output logic [SAMPLE_W-1:0] sample,
  output logic                sample_vld,
  output logic                rd_err
);

  localparam int unsigned SAMPLE_MSB = SAMPLE_LSB + SAMPLE_W - 1;

  logic                rd_ok;
  logic [SAMPLE_W-1:0] field;

  assign rd_ok  = rd_done &&  resp_is_ok(rresp);
  assign rd_err = rd_done && !resp_is_ok(rresp);
  assign field  = rdata[SAMPLE_MSB:SAMPLE_LSB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample     <= '0;
      sample_vld <= 1'b0;
    end else begin
      sample_vld <= rd_ok;
      if (rd_ok) sample <= field;
    end
  end

  // R6
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> !sample_vld);

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |=> ($stable(sample) && !sample_vld));

endmodule

// File: rtl/adc_err_counter.sv
module adc_err_counter #(
  parameter int unsigned ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_err,
  output logic [ERR_W-1:0] err_cnt
);

  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  function automatic logic [ERR_W-1:0] sat_inc(input logic [ERR_W-1:0] v);
    return (v == ERR_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)      err_cnt <= '0;
    else if (rd_err) err_cnt <= sat_inc(err_cnt);
  end

  // R7
  err_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_err && err_cnt != ERR_MAX) |=> (err_cnt == $past(err_cnt) + 1'b1));

  // R8
  err_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == ERR_MAX) |=> (err_cnt == ERR_MAX));

endmodule

// File: rtl/adc_poll_master.sv
module adc_poll_master #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SAMPLE_W   = 12,
  parameter int unsigned SAMPLE_LSB = 4,
  parameter int unsigned ERR_W      = 8,
  parameter logic [ADDR_W-1:0] RESULT_ADDR = 32'h4000_0200
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_done,
  output logic [ADDR_W-1:0]   m_araddr,
  output logic [2:0]          m_arprot,
  output logic                m_arvalid,
  input  logic                m_arready,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic [1:0]          m_rresp,
  input  logic                m_rvalid,
  output logic                m_rready,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [2:0]          m_awprot,
  output logic                m_awvalid,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wvalid,
  output logic                m_bready,
  output logic [SAMPLE_W-1:0] sample,
  output logic                sample_vld,
  output logic [ERR_W-1:0]    err_cnt
);

  logic rd_done;
  logic rd_err;

  // R10: write side never used
  assign m_awaddr  = '0;
  assign m_awprot  = 3'b000;
  assign m_awvalid = 1'b0;
  assign m_wdata   = '0;
  assign m_wstrb   = '0;
  assign m_wvalid  = 1'b0;
  assign m_bready  = 1'b1;
  assign m_arprot  = 3'b000;

  adc_poll_fsm #(
    .ADDR_W      (ADDR_W),
    .RESULT_ADDR (RESULT_ADDR)
  ) i_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_done (cfg_done),
    .arready  (m_arready),
    .rvalid   (m_rvalid),
    .arvalid  (m_arvalid),
    .araddr   (m_araddr),
    .rready   (m_rready),
    .rd_done  (rd_done)
  );

  adc_sample_capture #(
    .DATA_W     (DATA_W),
    .SAMPLE_W   (SAMPLE_W),
    .SAMPLE_LSB (SAMPLE_LSB)
  ) i_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_done    (rd_done),
    .rdata      (m_rdata),
    .rresp      (m_rresp),
    .sample     (sample),
    .sample_vld (sample_vld),
    .rd_err     (rd_err)
  );

  adc_err_counter #(
    .ERR_W (ERR_W)
  ) i_errs (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_err  (rd_err),
    .err_cnt (err_cnt)
  );

endmodule

// File: tb/test_adc_poll_master.sv
module test_adc_poll_master;

  localparam int CLK_PERIOD = 10;
  localparam int ERR_W      = 3;
  localparam logic [31:0] BASE = 32'h4000_0200;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_done = 1'b0;
  logic [31:0] m_araddr;
  logic [2:0]  m_arprot;
  logic        m_arvalid;
  logic        m_arready = 1'b0;
  logic [31:0] m_rdata = '0;
  logic [1:0]  m_rresp = '0;
  logic        m_rvalid = 1'b0;
  logic        m_rready;
  logic [31:0] m_awaddr;
  logic [2:0]  m_awprot;
  logic        m_awvalid;
  logic [31:0] m_wdata;
  logic [3:0]  m_wstrb;
  logic        m_wvalid;
  logic        m_bready;
  logic [11:0] sample;
  logic        sample_vld;
  logic [ERR_W-1:0] err_cnt;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [11:0]      exp_sample = '0;
  logic [ERR_W-1:0] exp_err = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_poll_master #(
    .ERR_W       (ERR_W),
    .RESULT_ADDR (BASE)
  ) i_adc_poll_master (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done),
    .m_araddr(m_araddr), .m_arprot(m_arprot), .m_arvalid(m_arvalid),
    .m_arready(m_arready), .m_rdata(m_rdata), .m_rresp(m_rresp),
    .m_rvalid(m_rvalid), .m_rready(m_rready),
    .m_awaddr(m_awaddr), .m_awprot(m_awprot), .m_awvalid(m_awvalid),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid),
    .m_bready(m_bready), .sample(sample), .sample_vld(sample_vld),
    .err_cnt(err_cnt)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_write_idle();
    // R10
    chk(m_awvalid == 0 && m_wvalid == 0 && m_bready == 1 &&
        m_awaddr == 0 && m_wdata == 0 && m_wstrb == 0 && m_awprot == 0, "R10",
        {m_awvalid, m_wvalid, m_bready}, 3'b001);
  endtask

  // drop: 0 none, 1 with data beat, 2 while address waits
  task automatic serve(input int ard, input int rd, input logic [31:0] d,
                       input logic [1:0] resp, input int drop);
    logic [31:0] a0;
    int t = 0;
    while (!m_arvalid && t < 50) begin
      @(negedge clk);
      t++;
    end
    chk(m_arvalid, "R2", m_arvalid, 1);
    a0 = m_araddr;
    chk(m_araddr == BASE && m_arprot == 0, "R3", m_araddr, BASE);
    if (drop == 2) cfg_done = 1'b0;
    for (int k = 0; k < ard; k++) begin
      @(negedge clk);
      chk(m_arvalid && m_araddr == a0, "R2", m_araddr, a0);
      chk(!m_rready, "R4", m_rready, 0);
    end
    m_arready = 1'b1;
    @(negedge clk);
    m_arready = 1'b0;
    chk(m_rready && !m_arvalid, "R4", {m_rready, m_arvalid}, 2'b10);
    for (int k = 0; k < rd; k++) begin
      @(negedge clk);
      chk(m_rready && !m_arvalid, "R4", {m_rready, m_arvalid}, 2'b10);
    end
    m_rvalid = 1'b1;
    m_rdata  = d;
    m_rresp  = resp;
    if (drop == 1) cfg_done = 1'b0;
    @(negedge clk);
    m_rvalid = 1'b0;
    m_rdata  = '0;
    if (resp == 2'b00) begin
      exp_sample = d[15:4];
      chk(sample_vld == 1, "R6", sample_vld, 1);
    end else begin
      if (exp_err != '1) exp_err = exp_err + 1'b1;
      chk(sample_vld == 0, "R7", sample_vld, 0);
    end
    chk(sample == exp_sample, "R6", sample, exp_sample);
    chk(err_cnt == exp_err, "R7", err_cnt, exp_err);
    if (drop != 0)
      chk(!m_arvalid && !m_rready, "R9", {m_arvalid, m_rready}, 0);
    else
      chk(m_arvalid, "R5", m_arvalid, 1);
    @(negedge clk);
    chk(!sample_vld, "R6", sample_vld, 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected<%0d", WATCHDOG, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11
    chk(!m_arvalid && !m_rready && sample == 0 && !sample_vld && err_cnt == 0,
        "R11", {m_arvalid, m_rready, sample_vld}, 0);
    chk_write_idle();
    // R1: no address while cfg_done low
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(!m_arvalid, "R1", m_arvalid, 0);
    end
    cfg_done = 1'b1;
    @(negedge clk);
    chk(m_arvalid, "R1", m_arvalid, 1);

    // sweep address delay, data delay, response code
    for (int a = 0; a < 4; a++)
      for (int r = 0; r < 4; r++)
        for (int s = 0; s < 4; s++)
          serve(a, r, 32'h0000_1000 * a + 32'h0000_0123 * (r + 1) + 32'h1357_0011 * s,
                2'(s), 0);
    // R8: 48 errors against a 3-bit counter
    chk(err_cnt == 3'd7, "R8", err_cnt, 7);

    // R9: drop in the completing cycle
    serve(1, 1, 32'h0000_ABCD, 2'b00, 1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!m_arvalid && !m_rready, "R9", {m_arvalid, m_rready}, 0);
    end
    cfg_done = 1'b1;
    @(negedge clk);
    chk(m_arvalid, "R1", m_arvalid, 1);
    // R9: drop while address waits; read completes, then idle
    serve(2, 0, 32'h0000_5670, 2'b00, 2);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!m_arvalid, "R9", m_arvalid, 0);
    end
    chk(sample == 12'h567, "R9", sample, 12'h567);
    chk_write_idle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule